// File: doc/BRIEF.md
# Glitch-Free Ratio-Switching Card Clock Divider

This block derives a card clock from a fast system clock. A two-bit select picks one of four ratios. The output's high and low phases each last 1, 2, 4 or 8 system clock cycles, so the card clock period is 2, 4, 8 or 16 cycles with an exact 50% duty cycle. The system clock is the reference at double rate: each reference period spans two system cycles, so the four ratios are the reference divided by 1, 2, 4 and 8.

The select may change while the clock is running. The new ratio is adopted only at the instant a low phase ends. The last pulse at the old ratio and the first pulse at the new one therefore both keep their full width, and no phase is ever cut short. The select bits pass through a synchronizer before use.

An enable from the activation sequencer gates the output. When the enable drops, the current high phase runs to full length and the output then stays low. When the enable returns, the output starts with a full-width high phase on the next clock edge.

Top module: `card_clk_div`

## Requirements
- R1: The select encoding gives a high phase and a low phase that each last N system clock cycles: 00 gives N=8, 01 gives N=4, 10 gives N=2 and 11 gives N=1. The output period is 2N cycles with equal high and low phases.
- R2: While reset is asserted the output is low, and after reset it stays low until the enable is asserted.
- R3: A ratio change is applied only at the end of a low phase. Every phase before the switch has the old length N_old, and every phase from the first new high phase onward has the new length N_new.
- R4: Across a ratio change, no high or low phase is shorter than min(N_old, N_new) cycles.
- R5: After a select change, the first high phase at the new ratio begins within 2·N_old + 3 system clock cycles.
- R6: When the enable is deasserted during a high phase, that phase completes at its full length N and the output then stays low while the enable remains low.
- R7: When the enable is asserted while the output is parked low, the output rises on the next clock edge and the first high phase has full length N for the current select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Ratio select (00:/8, 01:/4, 10:/2, 11:/1), synchronized internally |
| clk_en | input | 1 | Output enable from the activation sequencer |
| card_clk | output | 1 | Divided, gated card clock |

## Verification
The hardest case to reach from the ports is a select change that lands at each possible offset within the old period. A change just after a low phase ends makes the divider wait almost a full old period, which is the worst case for the switching latency. The bench sweeps every ordered pair of distinct ratios, waits a few periods between changes so the offset keeps drifting, and records every completed phase with its length and end cycle. It then checks the phase sequence around each switch for order, minimum width and latency.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    // Largest division exponent: half-phase lengths are 1 << (MAX_LOG2 - code)
    localparam int MAX_LOG2 = 3;
    localparam int CNT_W    = MAX_LOG2;
    localparam int LEN_W    = MAX_LOG2 + 1;
    localparam int SEL_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        RATIO_DIV8 = 2'b00,
        RATIO_DIV4 = 2'b01,
        RATIO_DIV2 = 2'b10,
        RATIO_DIV1 = 2'b11
    } ratio_e;

    typedef struct packed {
        logic   level;   // current card clock level
        logic   parked;  // held low waiting for enable
        ratio_e ratio;   // ratio currently in force
    } ckdiv_state_t;

    typedef struct packed {
        logic clr;
        logic hold;
    } cnt_cmd_t;

    function automatic logic [LEN_W-1:0] half_len(input ratio_e r);
        return LEN_W'(1) << (MAX_LOG2 - int'(r));
    endfunction

    function automatic logic [CNT_W-1:0] last_count(input ratio_e r);
        logic [LEN_W-1:0] h;
        h = half_len(r) - LEN_W'(1);
        return h[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/ckdiv_sync.sv
module ckdiv_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ckdiv_phase_cnt.sv
module ckdiv_phase_cnt #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hold,
    input  logic [W-1:0] last,
    output logic [W-1:0] count,
    output logic         term
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
        end else if (!hold) begin
            count_q <= count_q + W'(1);
        end
    end

    assign count = count_q;
    assign term  = (count_q == last);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        count_q <= last);  // R1

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ckdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RUN_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             clk_en,
    output logic             card_clk
);

    localparam ckdiv_state_t RST_STATE = '{level: 1'b0, parked: 1'b1, ratio: RATIO_DIV8};

    logic [SEL_W-1:0] sel_sync;
    ratio_e           sel_ratio;
    ckdiv_state_t     st_q, st_d;
    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] cnt;
    logic             term;

    ckdiv_sync #(
        .WIDTH  (SEL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SEL_W'(RATIO_DIV8))
    ) u_sel_sync (
        .clk(clk),
        .rst(rst),
        .d  (div_sel),
        .q  (sel_sync)
    );

    assign sel_ratio = ratio_e'(sel_sync);

    ckdiv_phase_cnt #(
        .W(CNT_W)
    ) u_phase_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmd.clr),
        .hold (cmd.hold),
        .last (last_count(st_q.ratio)),
        .count(cnt),
        .term (term)
    );

    // Phase sequencing: a ratio is adopted only when a low phase ends
    always_comb begin
        st_d = st_q;
        cmd  = '{clr: 1'b0, hold: 1'b0};
        if (st_q.parked) begin
            cmd.hold    = 1'b1;
            st_d.ratio  = sel_ratio;
            if (clk_en) begin
                st_d.level  = 1'b1;
                st_d.parked = 1'b0;
                cmd.clr     = 1'b1;
            end
        end else if (term) begin
            cmd.clr = 1'b1;
            if (st_q.level) begin
                st_d.level = 1'b0;
            end else begin
                st_d.ratio = sel_ratio;
                if (clk_en) begin
                    st_d.level = 1'b1;
                end else begin
                    st_d.parked = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk = st_q.level;

    // Assertion support: cycles the output has held its present level
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '1;
        end else if (st_d.level != st_q.level) begin
            run_q <= RUN_W'(1);
        end else if (run_q != '1) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    AST_HIGH_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(card_clk) |-> ($past(run_q) == RUN_W'(half_len($past(st_q.ratio)))));  // R1

    AST_NO_RUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(card_clk) |-> ($past(run_q) >= RUN_W'(half_len($past(st_q.ratio)))));  // R4

    AST_RATIO_AT_LOW_END: assert property (@(posedge clk) disable iff (rst)
        (st_q.ratio != $past(st_q.ratio)) |-> ($past(!card_clk) && (card_clk || st_q.parked)));  // R3

    AST_PARK_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(!clk_en) && $past(!card_clk)) |-> !card_clk);  // R6

endmodule

// File: tb/card_clk_div_tb.sv
module card_clk_div_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int PH_DEPTH   = 4096;

    logic       clk     = 1'b0;
    logic       rst     = 1'b1;
    logic [1:0] div_sel = 2'b11;
    logic       clk_en  = 1'b1;
    logic       card_clk;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_clk_div u_dut (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .clk_en  (clk_en),
        .card_clk(card_clk)
    );

    int   cyc = 0;
    int   run = 0;
    int   ph_n = 0;
    logic last_lvl = 1'b0;
    int   ph_len [PH_DEPTH];
    logic ph_lvl [PH_DEPTH];
    int   ph_end [PH_DEPTH];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Phase recorder: logs each completed phase with level, length, last cycle
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (card_clk !== last_lvl) begin
            ph_len[ph_n % PH_DEPTH] = run;
            ph_lvl[ph_n % PH_DEPTH] = last_lvl;
            ph_end[ph_n % PH_DEPTH] = cyc - 1;
            ph_n = ph_n + 1;
            run = 1;
            last_lvl = card_clk;
        end else begin
            run = run + 1;
        end
        if (cyc > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic int half_of(input int code);
        return 1 << (3 - code);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // R6 / R7: gate off mid-high, then gate on again
    task automatic gate_test(input int code);
        int n, k, highs, m, c0, st;
        n = half_of(code);
        div_sel = code[1:0];
        wait_cyc(40);
        while (card_clk !== 1'b0) wait_cyc(1);
        while (card_clk !== 1'b1) wait_cyc(1);
        k = n / 2;
        wait_cyc(k);
        clk_en = 1'b0;
        m = ph_n;
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            wait_cyc(1);
            if (card_clk) highs++;
        end
        chk(highs == n - 1 - k, "R6", "remaining high cycles after disable", highs, n - 1 - k);
        chk(ph_n - m == 1, "R6", "phases completed while disabled", ph_n - m, 1);
        chk(ph_len[m % PH_DEPTH] == n && ph_lvl[m % PH_DEPTH] == 1'b1, "R6",
            "last high phase width", ph_len[m % PH_DEPTH], n);
        c0 = cyc;
        clk_en = 1'b1;
        m = ph_n;
        wait_cyc(2 * n + 6);
        chk(ph_n - m >= 2, "R7", "phases after re-enable", ph_n - m, 2);
        st = ph_end[(m + 1) % PH_DEPTH] - ph_len[(m + 1) % PH_DEPTH] + 1;
        chk(st == c0 + 1, "R7", "first rise cycle after re-enable", st - c0, 1);
        chk(ph_len[(m + 1) % PH_DEPTH] == n, "R7", "first high width after re-enable",
            ph_len[(m + 1) % PH_DEPTH], n);
    endtask

    initial begin
        int highs;
        // R2: reset holds output low, then low while disabled
        highs = 0;
        for (int i = 0; i < 10; i++) begin
            wait_cyc(1);
            if (card_clk !== 1'b0) highs++;
        end
        chk(highs == 0, "R2", "high samples during reset", highs, 0);
        clk_en = 1'b0;
        rst = 1'b0;
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            wait_cyc(1);
            if (card_clk !== 1'b0) highs++;
        end
        chk(highs == 0, "R2", "high samples after reset while disabled", highs, 0);
        clk_en = 1'b1;

        // R1, R3, R4, R5: every ordered pair of distinct ratios
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a != b) begin
                    int na, nb, mn, m, c0, bad, bad_len, runts, first_new, order_bad, st;
                    na = half_of(a);
                    nb = half_of(b);
                    mn = (na < nb) ? na : nb;
                    div_sel = a[1:0];
                    wait_cyc(40 + a + b);
                    m = ph_n;
                    wait_cyc(8 * na + 2);
                    chk(ph_n - m >= 4, "R1", "phases observed at steady ratio", ph_n - m, 4);
                    bad = 0;
                    bad_len = na;
                    for (int i = m; i < ph_n; i++) begin
                        if (ph_len[i % PH_DEPTH] != na) begin
                            bad++;
                            bad_len = ph_len[i % PH_DEPTH];
                        end
                    end
                    chk(bad == 0, "R1", "steady phase length", bad_len, na);

                    c0 = cyc;
                    div_sel = b[1:0];
                    m = ph_n;
                    wait_cyc(2 * na + 3 + 8 * nb + 4);
                    runts = 0;
                    order_bad = 0;
                    first_new = -1;
                    for (int i = m; i < ph_n; i++) begin
                        int l;
                        l = ph_len[i % PH_DEPTH];
                        if (l < mn) runts++;
                        if (first_new < 0) begin
                            if (ph_lvl[i % PH_DEPTH] == 1'b1 && l == nb) first_new = i;
                            else if (l != na) order_bad++;
                        end else if (l != nb) begin
                            order_bad++;
                        end
                    end
                    chk(runts == 0, "R4", "phases shorter than min width", runts, 0);
                    chk(first_new >= 0 && order_bad == 0, "R3", "out-of-order phase widths", order_bad, 0);
                    st = (first_new >= 0)
                         ? ph_end[first_new % PH_DEPTH] - nb + 1 - c0 : 99999;
                    chk(st <= 2 * na + 3, "R5", "cycles to first new-ratio high", st, 2 * na + 3);
                end
            end
        end

        gate_test(0);
        gate_test(1);
        gate_test(3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule